// File: doc/BRIEF.md
# Branch Condition Flag Evaluator

This block decides whether a 4-bit condition code is satisfied by the four arithmetic flags of a processor status word. A conditional branch uses the single-bit verdict to decide whether to take the branch. A set-flag operation uses the same verdict, widened to a full data word, as the value it writes to a destination register: 1 when the condition holds and 0 when it does not.

The status word is kept in a register inside the block and is loaded through a synchronous write port, so any flag pattern can be placed in it. Only the four low bits feed the evaluator. The conditions cover single flags, unsigned higher / not-higher, the signed orderings, and always / never. They are arranged in complementary pairs: code n and code n+8 are logical inverses.

The block has no state machine. The evaluator is purely combinational and reads the registered status word. A new condition code takes effect in the same cycle, and a status write takes effect from the cycle after its clock edge.

Top module: `cond_unit`

## Requirements
- R1: The status word register clears to zero on reset. On a clock edge where `sw_we` is high it loads `sw_wdata` in full, including the bits above bit 3. Without a write it holds its value, and it is visible on `status_word`.
- R2: Flag positions in the status word are bit 0 zero (Z), bit 1 sign (S), bit 2 overflow (V) and bit 3 carry (C). Code 0 is V, code 1 is C, code 2 is Z and code 4 is S. Codes 8, 9, 10 and 12 are their complements.
- R3: Code 3 (not higher) is true when C or Z is set. Code 11 (higher) is true only when both are clear.
- R4: Code 6 (less than) is true when S XOR V is 1. Code 14 (greater or equal) is its complement.
- R5: Code 7 (less or equal) is true when (S XOR V) OR Z is 1. Code 15 (greater than) is its complement.
- R6: Code 5 is always true and code 13 is never true, whatever the flags are.
- R7: For every n from 0 to 7, code n and code n+8 give opposite results for the same flags.
- R8: Status bits above bit 3 have no effect on the verdict.
- R9: `setf_value` is 1 when the selected condition holds and 0 otherwise, with all upper bits zero.
- R10: The verdict follows `cond_sel` in the same cycle. It follows a status write from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Status word write enable |
| sw_wdata | input | SW_W | Status word write data |
| cond_sel | input | 4 | Condition code to evaluate |
| status_word | output | SW_W | Registered status word |
| cond_true | output | 1 | Branch verdict: selected condition holds |
| setf_value | output | DATA_W | Set-flag result, 0 or 1 zero-extended |

## Verification
The clocked assertions assume that `sw_we`, `sw_wdata` and `cond_sel` are stable around the rising edge and are never X once reset is released. The stimulus meets this by driving every input only at falling edges. The pair-inverse check assumes that the flags settle before it is sampled, which holds because they come straight from a register. The random part of the stimulus draws full-width status words, so the upper bits vary freely. It also holds the condition code steady across writes that change only those upper bits, which exercises the check that they are ignored.

// File: rtl/cond_pkg.sv
package cond_pkg;
    localparam int NUM_COND = 16;
    localparam int HALF_COND = NUM_COND / 2;

    typedef enum logic [3:0] {
        CC_OVF    = 4'd0,
        CC_CARRY  = 4'd1,
        CC_ZERO   = 4'd2,
        CC_NHI    = 4'd3,
        CC_NEG    = 4'd4,
        CC_ALWAYS = 4'd5,
        CC_LT     = 4'd6,
        CC_LE     = 4'd7,
        CC_NOVF   = 4'd8,
        CC_NCARRY = 4'd9,
        CC_NZERO  = 4'd10,
        CC_HI     = 4'd11,
        CC_POS    = 4'd12,
        CC_NEVER  = 4'd13,
        CC_GE     = 4'd14,
        CC_GT     = 4'd15
    } cond_e;

    // low nibble of the status word: bit3 carry, bit2 overflow, bit1 sign, bit0 zero
    typedef struct packed {
        logic cy;
        logic ov;
        logic sg;
        logic zr;
    } flags_t;
endpackage

// File: rtl/status_reg.sv
module status_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_pkg::*;
(
    input  flags_t     flg,
    input  logic [3:0] sel,
    output logic       hit
);
    logic [NUM_COND-1:0] hits;
    logic                lt_s;

    always_comb begin
        lt_s             = flg.sg ^ flg.ov;
        hits[CC_OVF]     = flg.ov;
        hits[CC_CARRY]   = flg.cy;
        hits[CC_ZERO]    = flg.zr;
        hits[CC_NHI]     = flg.cy | flg.zr;
        hits[CC_NEG]     = flg.sg;
        hits[CC_ALWAYS]  = 1'b1;
        hits[CC_LT]      = lt_s;
        hits[CC_LE]      = lt_s | flg.zr;
        hits[CC_NOVF]    = ~flg.ov;
        hits[CC_NCARRY]  = ~flg.cy;
        hits[CC_NZERO]   = ~flg.zr;
        hits[CC_HI]      = ~flg.cy & ~flg.zr;
        hits[CC_POS]     = ~flg.sg;
        hits[CC_NEVER]   = 1'b0;
        hits[CC_GE]      = flg.sg ~^ flg.ov;
        hits[CC_GT]      = (flg.sg ~^ flg.ov) & ~flg.zr;
    end

    assign hit = hits[sel];

    for (genvar k = 0; k < HALF_COND; k++) begin : g_pair
        always_comb begin
            AST_PAIR_INVERSE: assert (hits[k] != hits[k+HALF_COND]); // R7
        end
    end
endmodule

// File: rtl/cond_unit.sv
module cond_unit
    import cond_pkg::*;
#(
    parameter int SW_W   = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [SW_W-1:0]   sw_wdata,
    input  logic [3:0]        cond_sel,
    output logic [SW_W-1:0]   status_word,
    output logic              cond_true,
    output logic [DATA_W-1:0] setf_value
);
    localparam int FLAG_W = $bits(flags_t);

    logic [SW_W-1:0] sw_q;
    flags_t          flags;

    status_reg #(.W(SW_W)) i_status (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sw_we),
        .wdata (sw_wdata),
        .q     (sw_q)
    );

    assign flags = flags_t'(sw_q[FLAG_W-1:0]);

    cond_eval i_eval (
        .flg (flags),
        .sel (cond_sel),
        .hit (cond_true)
    );

    assign status_word = sw_q;
    assign setf_value  = {{(DATA_W-1){1'b0}}, cond_true};

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> status_word == '0); // R1
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_we) && $past(rst_n) |-> status_word == $past(sw_wdata)); // R1
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_we) && $past(rst_n) |-> $stable(status_word)); // R1
    AST_ALWAYS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == CC_ALWAYS |-> cond_true); // R6
    AST_NEVER_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == CC_NEVER |-> !cond_true); // R6
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cond_sel == CC_ZERO |-> cond_true == status_word[0]); // R2
    AST_UPPER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(sw_we) && $past(sw_wdata[FLAG_W-1:0]) == $past(status_word[FLAG_W-1:0])
        && $stable(cond_sel) |-> $stable(cond_true)); // R8
endmodule

// File: tb/test_cond_unit.sv
module test_cond_unit;
    localparam int SW_W   = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sw_we = 1'b0;
    logic [SW_W-1:0]   sw_wdata = '0;
    logic [3:0]        cond_sel = 4'd0;
    logic [SW_W-1:0]   status_word;
    logic              cond_true;
    logic [DATA_W-1:0] setf_value;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [SW_W-1:0] shadow = '0;

    always #5 clk = ~clk;

    cond_unit #(.SW_W(SW_W), .DATA_W(DATA_W)) i_cond_unit (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .cond_sel(cond_sel), .status_word(status_word),
        .cond_true(cond_true), .setf_value(setf_value)
    );

    function automatic bit ref_cond(input logic [3:0] f, input logic [3:0] sel);
        bit z = f[0]; bit s = f[1]; bit v = f[2]; bit c = f[3];
        bit base;
        case (sel[2:0])
            3'd0: base = v;
            3'd1: base = c;
            3'd2: base = z;
            3'd3: base = c || z;
            3'd4: base = s;
            3'd5: base = 1'b1;
            3'd6: base = s != v;
            default: base = (s != v) || z;
        endcase
        return sel[3] ? !base : base;
    endfunction

    task automatic write_sw(input logic [SW_W-1:0] val);
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = val;
        @(negedge clk);
        sw_we = 1'b0;
        shadow = val;
    endtask

    task automatic chk_cond(input string req, input logic [3:0] sel);
        logic [DATA_W-1:0] exp;
        cond_sel = sel;
        #1;
        exp = DATA_W'(ref_cond(shadow[3:0], sel));
        total++;
        if (setf_value !== exp || cond_true !== exp[0]) begin
            bad++;
            $display("FAIL %s sel=%0d sw=%h actual=%h/%b expected=%h", req, sel, shadow, setf_value, cond_true, exp);
        end
    endtask

    task automatic chk_sw(input string req);
        total++;
        if (status_word !== shadow) begin
            bad++;
            $display("FAIL %s status actual=%h expected=%h", req, status_word, shadow);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_sw("R1 reset");
        chk_cond("R2 reset zero clear", 4'd2);

        // all ones: Z, C, N, V true; complements false
        write_sw('1);
        chk_sw("R1 load");
        for (int k = 0; k < 16; k++) chk_cond("R2 R7 all ones", k[3:0]);
        write_sw('0);
        for (int k = 0; k < 16; k++) chk_cond("R2 R7 all zero", k[3:0]);

        // sweep 0..15: set-flag reproduces each flag bit
        for (int v = 0; v < 16; v++) begin
            write_sw(SW_W'(v));
            chk_cond("R9 setf zero", 4'd2);
            chk_cond("R9 setf sign", 4'd4);
            chk_cond("R9 setf ovf", 4'd0);
            chk_cond("R9 setf carry", 4'd1);
            chk_cond("R3 nh", 4'd3);  chk_cond("R3 hi", 4'd11);
            chk_cond("R4 lt", 4'd6);  chk_cond("R4 ge", 4'd14);
            chk_cond("R5 le", 4'd7);  chk_cond("R5 gt", 4'd15);
            chk_cond("R6 always", 4'd5); chk_cond("R6 never", 4'd13);
        end

        // upper bits ignored, verdict holds across the write
        write_sw(16'h0006);
        chk_cond("R8 base", 4'd6);
        cond_sel = 4'd6;
        write_sw(16'hFFF6);
        chk_sw("R1 upper stored");
        chk_cond("R8 upper ignored", 4'd6);
        chk_cond("R8 upper ignored gt", 4'd15);

        // timing: write edge -> next cycle; sel -> same cycle
        cond_sel = 4'd2;
        @(negedge clk);
        sw_we = 1'b1; sw_wdata = 16'h0001;
        @(posedge clk); #1;
        total++;
        if (cond_true !== 1'b1) begin
            bad++; $display("FAIL R10 after edge actual=%b expected=1", cond_true);
        end
        @(negedge clk); sw_we = 1'b0; shadow = 16'h0001;
        chk_cond("R10 sel same cycle", 4'd10);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 2) != 0) write_sw(SW_W'($urandom));
            else @(negedge clk);
            chk_sw("R1 random");
            chk_cond("R7 random", 4'($urandom_range(0, 15)));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule